// File: doc/BRIEF.md
# ATA PIO cycle timing engine

This block turns one host request into a single programmed-I/O register access on a parallel ATA bus. A request carries a direction, a five-bit register address, write data and a device number. The engine selects the chip select and the three address lines from the address. It then steps through four counted phases: address setup, strobe, write hold and end-of-cycle recovery. It drives the read or the write strobe and, on writes, the data bus with its output enable. On reads it captures the word the device returns.

Three timing sets reach the engine as plain inputs: one for the command and control registers, and one each for the data register of device 0 and of device 1. The address and device number pick the set for the access. A set can also let the device stretch the strobe through its ready line. A one-clock done pulse marks the end of the strobe, and a busy flag covers the whole access, recovery included.

Top module: `pio_cycle_engine`

## Requirements
- R1: A request (`reqValid` high at a rising clock edge) starts an access only when the engine is idle and `reqAddr[4]` is 1. A request with `reqAddr[4]` = 0 leaves every bus output and `busy` unchanged.
- R2: `reqAddr[3]` = 1 selects `cs1N`, and 0 selects `cs0N`. `reqAddr[2:0]` drives `da`. The selected chip select is low from the first setup clock to the last hold clock, and both are high at all other times.
- R3: After the accepting edge the access holds setup for T1 clocks, then strobe for T2 clocks, then hold for T4 clocks, then recovery for Teoc clocks. Both strobes stay high outside the strobe phase.
- R4: A phase count of zero lasts one clock.
- R5: On a read, `diorN` is low for the strobe phase. `ddIn` is captured at the edge that ends the strobe, and `rdData` holds it while `done` is high.
- R6: On a write, `diowN` is low for the strobe phase. `ddOut` carries the request's write data, and `ddOe` is high from the first setup clock to the last hold clock. `ddOe` stays low throughout a read.
- R7: When the selected set's enable bit is 1, the strobe phase stays active past T2 for as long as `iordy` is low at the end of a strobe clock. When the bit is 0, `iordy` has no effect.
- R8: Each timing input is packed as bit 32 = ready enable, [31:24] = Teoc, [23:16] = T4, [15:8] = T2, [7:0] = T1. Accesses with `reqAddr[3]` = 1 or a nonzero `reqAddr[2:0]` use `timCmd`. Accesses with `reqAddr[3:0]` = 0 use `timDev0` when `reqDev` = 0 and `timDev1` when `reqDev` = 1.
- R9: `done` is high for exactly the first clock after the strobe ends. `busy` is high from the accepting edge until recovery ends. Requests that arrive while `busy` is high are dropped.
- R10: A low `arstN` (asynchronous) or a high `srst` (at a clock edge) aborts any access and returns the engine to idle: strobes and chip selects high, `ddOe`, `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 5 | [4] device space, [3] control block, [2:0] register address |
| reqDev | input | 1 | Device number for data-register accesses |
| reqWdata | input | 16 | Write data |
| timCmd | input | 33 | Timing set for command/control registers |
| timDev0 | input | 33 | Timing set for device 0 data register |
| timDev1 | input | 33 | Timing set for device 1 data register |
| iordy | input | 1 | Device ready |
| ddIn | input | 16 | Data bus from device |
| ddOut | output | 16 | Data bus to device |
| ddOe | output | 1 | Data bus output enable |
| cs0N | output | 1 | Command block chip select, active low |
| cs1N | output | 1 | Control block chip select, active low |
| da | output | 3 | Register address lines |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| rdData | output | 16 | Captured read data |
| done | output | 1 | Strobe-complete pulse |
| busy | output | 1 | Access in progress |

## Verification
A wrong phase count or phase register shows as a chip-select or strobe edge that lands a clock early or late. It also moves the done pulse and the fall of busy, and it can be seen within the same access. A wrong set choice shows as phase lengths that match a different set, which the sweep makes distinct from the chosen one. A bad capture register gives a wrong `rdData` at the done clock. A stuck idle state shows in the clocks that follow each access: a dropped request starts a second cycle there, or busy fails to fall.

// File: rtl/pio_engine_pkg.sv
package pio_engine_pkg;

  localparam int CNT_W    = 8;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int NUM_SETS = 3;
  localparam int TSET_W   = 4 * CNT_W + 1;
  localparam int SET_IDX_W = $clog2(NUM_SETS);

  // Packed MSB first: ready enable, recovery, hold, strobe, setup.
  typedef struct packed {
    logic             iordyEn;
    logic [CNT_W-1:0] tEoc;
    logic [CNT_W-1:0] tHold;
    logic [CNT_W-1:0] tStrobe;
    logic [CNT_W-1:0] tSetup;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOVER
  } phase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic capture;
    logic busActive;
    logic strobeActive;
  } ctrl_t;

  // Counter preload: a phase lasts max(count,1) clocks.
  function automatic logic [CNT_W-1:0] loadOf(input logic [CNT_W-1:0] count);
    return (count == '0) ? '0 : count - 1'b1;
  endfunction

  // Set 0 serves command/control registers, sets 1/2 the data register per device.
  function automatic logic [SET_IDX_W-1:0] pickSet(input logic [3:0] sel, input logic dev);
    if (sel[3] || (sel[2:0] != 3'd0)) return SET_IDX_W'(0);
    return dev ? SET_IDX_W'(2) : SET_IDX_W'(1);
  endfunction

endpackage

// File: rtl/pio_engine_ctrl.sv
module pio_engine_ctrl
  import pio_engine_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    srst,
  input  logic    reqValid,
  input  logic    reqTarget,
  input  timing_t selTim,
  input  logic    iordy,
  output ctrl_t   ctl,
  output logic    busy,
  output logic    done
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tStrobeQ;
  logic [CNT_W-1:0] tHoldQ;
  logic [CNT_W-1:0] tEocQ;
  logic             iordyEnQ;
  logic             doneQ;
  logic             accept;
  logic             lastTick;
  logic             strobeEnd;

  assign accept    = reqValid && reqTarget && (phase == PH_IDLE);
  assign lastTick  = (cnt == '0);
  assign strobeEnd = (phase == PH_STROBE) && lastTick && (!iordyEnQ || iordy);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tStrobeQ <= '0;
      tHoldQ   <= '0;
      tEocQ    <= '0;
      iordyEnQ <= 1'b0;
      doneQ    <= 1'b0;
    end else if (srst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tStrobeQ <= '0;
      tHoldQ   <= '0;
      tEocQ    <= '0;
      iordyEnQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobeEnd;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_SETUP;
            cnt      <= loadOf(selTim.tSetup);
            tStrobeQ <= selTim.tStrobe;
            tHoldQ   <= selTim.tHold;
            tEocQ    <= selTim.tEoc;
            iordyEnQ <= selTim.iordyEn;
          end
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_STROBE;
            cnt   <= loadOf(tStrobeQ);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (strobeEnd) begin
            phase <= PH_HOLD;
            cnt   <= loadOf(tHoldQ);
          end else if (!lastTick) begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastTick) begin
            phase <= PH_RECOVER;
            cnt   <= loadOf(tEocQ);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOVER: begin
          if (lastTick) phase <= PH_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load         = accept;
    ctl.capture      = strobeEnd;
    ctl.busActive    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctl.strobeActive = (phase == PH_STROBE);
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;

  // R9: done only follows a clock spent in the strobe phase
  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!arstN || srst)
    done |-> $past(phase == PH_STROBE));

  // R9: busy only falls out of the recovery phase
  assert_busy_ends_in_recovery_R9: assert property (@(posedge clk) disable iff (!arstN || srst)
    $fell(busy) |-> $past(phase == PH_RECOVER));

  // R7: an unready device keeps the strobe phase alive
  assert_iordy_stretch_R7: assert property (@(posedge clk) disable iff (!arstN || srst)
    (phase == PH_STROBE && lastTick && iordyEnQ && !iordy) |=> (phase == PH_STROBE));

  // R3: the strobe phase is always entered from setup
  assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!arstN || srst)
    $rose(ctl.strobeActive) |-> $past(phase == PH_SETUP));

endmodule

// File: rtl/pio_engine_datapath.sv
module pio_engine_datapath
  import pio_engine_pkg::*;
(
  input  logic              clk,
  input  logic              arstN,
  input  logic              srst,
  input  ctrl_t             ctl,
  input  logic              reqWrite,
  input  logic [3:0]        reqSel,
  input  logic              reqDev,
  input  logic [DATA_W-1:0] reqWdata,
  input  timing_t           timSets [NUM_SETS],
  output timing_t           selTim,
  input  logic [DATA_W-1:0] ddIn,
  output logic [DATA_W-1:0] ddOut,
  output logic              ddOe,
  output logic              cs0N,
  output logic              cs1N,
  output logic [2:0]        da,
  output logic              diorN,
  output logic              diowN,
  output logic [DATA_W-1:0] rdData
);

  logic [SET_IDX_W-1:0] setIdx;
  logic [NUM_SETS-1:0]  setHit;
  logic [3:0]           selQ;
  logic                 writeQ;
  logic [DATA_W-1:0]    wdataQ;

  assign setIdx = pickSet(reqSel, reqDev);

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_hit
    assign setHit[g] = (setIdx == SET_IDX_W'(g));
  end

  always_comb begin
    selTim = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (setHit[i]) selTim = timSets[i];
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      selQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rdData <= '0;
    end else if (srst) begin
      selQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (ctl.load) begin
        selQ   <= reqSel;
        writeQ <= reqWrite;
        wdataQ <= reqWdata;
      end
      if (ctl.capture && !writeQ) rdData <= ddIn;
    end
  end

  assign cs0N  = !(ctl.busActive && !selQ[3]);
  assign cs1N  = !(ctl.busActive && selQ[3]);
  assign da    = selQ[2:0];
  assign diorN = !(ctl.strobeActive && !writeQ);
  assign diowN = !(ctl.strobeActive && writeQ);
  assign ddOe  = ctl.busActive && writeQ;
  assign ddOut = wdataQ;

  // R3: never both strobes at once
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!arstN || srst)
    !(!diorN && !diowN));

  // R2: a strobe only with exactly one chip select low
  assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!arstN || srst)
    (!diorN || !diowN) |-> (cs0N != cs1N));

  // R6: output enable never overlaps a read strobe
  assert_oe_not_on_read_R6: assert property (@(posedge clk) disable iff (!arstN || srst)
    ddOe |-> diorN);

  // R2: address lines stay put while a chip select is held
  assert_da_stable_R2: assert property (@(posedge clk) disable iff (!arstN || srst)
    (!(cs0N && cs1N) && $past(!(cs0N && cs1N))) |-> $stable(da));

endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_engine_pkg::*;
(
  input  logic              clk,
  input  logic              arstN,
  input  logic              srst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDev,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [TSET_W-1:0] timCmd,
  input  logic [TSET_W-1:0] timDev0,
  input  logic [TSET_W-1:0] timDev1,
  input  logic              iordy,
  input  logic [DATA_W-1:0] ddIn,
  output logic [DATA_W-1:0] ddOut,
  output logic              ddOe,
  output logic              cs0N,
  output logic              cs1N,
  output logic [2:0]        da,
  output logic              diorN,
  output logic              diowN,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              busy
);

  timing_t timSets [NUM_SETS];
  timing_t selTim;
  ctrl_t   ctl;

  assign timSets[0] = timing_t'(timCmd);
  assign timSets[1] = timing_t'(timDev0);
  assign timSets[2] = timing_t'(timDev1);

  pio_engine_ctrl u_ctrl (
    .clk       (clk),
    .arstN     (arstN),
    .srst      (srst),
    .reqValid  (reqValid),
    .reqTarget (reqAddr[4]),
    .selTim    (selTim),
    .iordy     (iordy),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  pio_engine_datapath u_datapath (
    .clk      (clk),
    .arstN    (arstN),
    .srst     (srst),
    .ctl      (ctl),
    .reqWrite (reqWrite),
    .reqSel   (reqAddr[3:0]),
    .reqDev   (reqDev),
    .reqWdata (reqWdata),
    .timSets  (timSets),
    .selTim   (selTim),
    .ddIn     (ddIn),
    .ddOut    (ddOut),
    .ddOe     (ddOe),
    .cs0N     (cs0N),
    .cs1N     (cs1N),
    .da       (da),
    .diorN    (diorN),
    .diowN    (diowN),
    .rdData   (rdData)
  );

endmodule

// File: tb/pio_cycle_engine_bench.sv
module pio_cycle_engine_bench;
  import pio_engine_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic arstN, srst, reqValid, reqWrite, reqDev, iordy;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata, ddIn, ddOut, rdData;
  logic ddOe, cs0N, cs1N, diorN, diowN, done, busy;
  logic [2:0] da;
  timing_t tims [NUM_SETS];

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_engine u_pio_cycle_engine (
    .clk(clk), .arstN(arstN), .srst(srst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqDev(reqDev), .reqWdata(reqWdata),
    .timCmd(tims[0]), .timDev0(tims[1]), .timDev1(tims[2]),
    .iordy(iordy), .ddIn(ddIn), .ddOut(ddOut), .ddOe(ddOe), .cs0N(cs0N), .cs1N(cs1N),
    .da(da), .diorN(diorN), .diowN(diowN), .rdData(rdData), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic checkIdle(input string what);
    check(cs0N === 1'b1 && cs1N === 1'b1, {what, " chip selects high"}, {cs1N, cs0N}, 3);
    check(diorN === 1'b1 && diowN === 1'b1, {what, " strobes high"}, {diowN, diorN}, 3);
    check(ddOe === 1'b0 && busy === 1'b0 && done === 1'b0, {what, " oe/busy/done low"},
          {ddOe, busy, done}, 0);
  endtask

  // One full access; the expected waveform is computed from the phase counts.
  task automatic runCycle(input bit wr, input bit a5, input logic [2:0] daV, input bit dev,
                          input timing_t t, input int lag, input logic [15:0] wdat,
                          input logic [15:0] rv, input string tag);
    int e1, e2, e4, ee, busEnd, total, sCount;
    int errCs, errDa, errStb, errOe, errBusy, errDone;
    logic [15:0] rdGot;
    bit inBus, inStb;
    e1 = eff(int'(t.tSetup));
    e2 = eff(int'(t.tStrobe));
    if (t.iordyEn && lag + 1 > e2) e2 = lag + 1;
    e4 = eff(int'(t.tHold));
    ee = eff(int'(t.tEoc));
    busEnd = e1 + e2 + e4;
    total = busEnd + ee;
    sCount = 0; errCs = 0; errDa = 0; errStb = 0; errOe = 0; errBusy = 0; errDone = 0;
    rdGot = 'x;
    reqValid = 1'b1; reqWrite = wr; reqAddr = {1'b1, a5, daV}; reqDev = dev;
    reqWdata = wdat; iordy = 1'b0; ddIn = ~rv;
    @(negedge clk);
    for (int idx = 0; idx < total + 3; idx++) begin
      inBus = idx < busEnd;
      inStb = (idx >= e1) && (idx < e1 + e2);
      if (cs0N !== !(inBus && !a5) || cs1N !== !(inBus && a5)) errCs++;
      if (inBus && da !== daV) errDa++;
      if (diorN !== !(inStb && !wr) || diowN !== !(inStb && wr)) errStb++;
      if (ddOe !== (inBus && wr) || (ddOe && ddOut !== wdat)) errOe++;
      if (busy !== (idx < total)) errBusy++;
      if (done !== (idx == e1 + e2)) errDone++;
      if (idx == e1 + e2) rdGot = rdData;
      // a request while busy (idx 0 = setup) must be dropped (R9)
      reqValid = (idx == 0);
      if (!diorN || !diowN) begin
        ddIn = rv;
        iordy = (sCount >= lag);
        sCount++;
      end else begin
        ddIn = ~rv;
        iordy = 1'b0;
      end
      @(negedge clk);
    end
    check(errCs == 0, {"R2 chip select ", tag}, errCs, 0);
    check(errDa == 0, {"R2 address lines ", tag}, errDa, 0);
    check(errStb == 0, {"R3 R4 R7 R8 strobe timing ", tag}, errStb, 0);
    check(errOe == 0, {"R6 output enable/data ", tag}, errOe, 0);
    check(errBusy == 0, {"R9 busy window ", tag}, errBusy, 0);
    check(errDone == 0, {"R9 done pulse ", tag}, errDone, 0);
    if (!wr) check(rdGot === rv, {"R5 read capture ", tag}, rdGot, rv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    timing_t filler;
    filler = {1'b0, 8'd5, 8'd4, 8'd6, 8'd5};
    arstN = 1'b0; srst = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqDev = 1'b0; reqWdata = '0; iordy = 1'b0; ddIn = '0;
    for (int i = 0; i < NUM_SETS; i++) tims[i] = filler;
    #1;
    checkIdle("R10 reset state");
    repeat (3) @(negedge clk);
    arstN = 1'b1;
    @(negedge clk);
    checkIdle("R10 after reset release");

    // R1: no start without the device-space bit
    reqValid = 1'b1; reqAddr = 5'b0_1010;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      checkIdle("R1 non-device request ignored");
      @(negedge clk);
    end

    // R3 R4 R8: sweep of phase counts over every set, both directions
    for (int tg = 0; tg < NUM_SETS; tg++)
      for (int t1 = 0; t1 < 4; t1++)
        for (int t2 = 0; t2 < 4; t2++)
          for (int t4 = 0; t4 < 3; t4++)
            for (int te = 0; te < 3; te++)
              for (int wr = 0; wr < 2; wr++) begin
                int k;
                bit a5;
                logic [2:0] daV;
                bit dev;
                for (int i = 0; i < NUM_SETS; i++) tims[i] = filler;
                tims[tg] = {1'b0, 8'(te), 8'(t4), 8'(t2), 8'(t1)};
                k = (t1 + 4 * t2 + 3 * t4 + te + wr) % 15 + 1;
                if (tg == 0) begin
                  a5 = k[3]; daV = k[2:0]; dev = t2[0];
                end else begin
                  a5 = 1'b0; daV = 3'd0; dev = (tg == 2);
                end
                runCycle(wr[0], a5, daV, dev, tims[tg], 1000,
                         16'h1234 ^ 16'(k * 977 + t2), 16'hA5C3 ^ 16'(k * 313 + t1),
                         $sformatf("R8 set=%0d t1=%0d t2=%0d t4=%0d te=%0d wr=%0d",
                                   tg, t1, t2, t4, te, wr));
              end

    // R7: ready stretching with the enable set, reads and writes
    for (int lag = 0; lag < 6; lag++)
      for (int wr = 0; wr < 2; wr++) begin
        tims[0] = {1'b1, 8'd1, 8'd1, 8'd2, 8'd1};
        runCycle(wr[0], 1'b1, 3'd6, 1'b0, tims[0], lag, 16'hBEEF, 16'h0F0F,
                 $sformatf("R7 lag=%0d wr=%0d", lag, wr));
      end
    tims[0] = {1'b1, 8'd0, 8'd0, 8'd0, 8'd0};
    runCycle(1'b0, 1'b0, 3'd7, 1'b0, tims[0], 4, 16'h0, 16'h7E81, "R7 R4 zero strobe count");

    // R3: reset-default mode-0 counts on device 1 data register
    tims[2] = {1'b0, 8'd23, 8'd2, 8'd28, 8'd6};
    runCycle(1'b1, 1'b0, 3'd0, 1'b1, tims[2], 1000, 16'hC0DE, 16'h0, "R3 mode0 write");
    runCycle(1'b0, 1'b0, 3'd0, 1'b1, tims[2], 1000, 16'h0, 16'h5AA5, "R3 mode0 read");

    // R10: synchronous reset in mid-strobe
    tims[0] = {1'b0, 8'd10, 8'd10, 8'd10, 8'd10};
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 5'b1_1010; reqWdata = 16'h1111;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (12) @(negedge clk);
    srst = 1'b1;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    checkIdle("R10 synchronous reset");
    runCycle(1'b0, 1'b1, 3'd2, 1'b0, tims[0], 1000, 16'h0, 16'h3C3C, "R10 after srst");

    // R10: asynchronous reset in mid-strobe
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 5'b1_0011;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (12) @(negedge clk);
    arstN = 1'b0;
    #1;
    checkIdle("R10 asynchronous reset");
    @(negedge clk);
    arstN = 1'b1;
    @(negedge clk);
    runCycle(1'b1, 1'b0, 3'd3, 1'b0, tims[0], 1000, 16'h9669, 16'h0, "R10 after arstN");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule